// File: doc/BRIEF.md
# Receive bit sequencer

This block runs the reception of one asynchronous serial character. The clock runs sixteen times faster than the bit rate. A start pulse from an upstream start detector loads a cycle counter and a bit counter. From then on the cycle counter divides every bit period into sixteen clocks. Each time the top bit of the cycle counter rises, the block takes one sample of the already filtered receive line. These samples land in the middle of each bit.

The first sample is taken on the start bit, the next eight on the data bits (least significant first), and the tenth on the stop bit. The data samples are shifted into a right-shifting register whose contents appear in parallel on the output. The stop-bit sample sets or clears a framing flag. After the stop-bit period both counters freeze at their all-ones value and the done flag is raised. The flag stays high until the next start pulse.

A start pulse has priority at all times: it restarts the frame timing from its own edge, even in the middle of a character.

Top module: `rx_bit_sequencer`

## Requirements
- R1: After reset, done_o is 1, data_o is all zeros and frame_err_o is 0.
- R2: A start_i sampled high on a rising edge makes done_o 0 right after that edge.
- R3: Counting the edge that samples start_i as edge 1, done_o stays 0 through edge 158 and becomes 1 after edge 159 (that is, (DATA_W+2)*16-1).
- R4: The line is sampled on edges 9+16*j. The sample with j=1..8 ends in data_o[j-1] (least significant bit first, each new sample enters at the MSB and the register shifts right), so data_o is complete after edge 137.
- R5: The start-bit sample (j=0) is no longer present in data_o once the frame is complete.
- R6: The sample with j=9 (stop bit, edge 153) sets frame_err_o to the inverse of the line level: a 0 stop bit gives frame_err_o = 1 and a 1 stop bit gives frame_err_o = 0.
- R7: A start pulse clears frame_err_o right after its edge and overrides a stop-bit sample taken on the same edge. Between a start pulse and the stop-bit sample, frame_err_o stays 0.
- R8: While done_o is 1 and no start pulse arrives, done_o, data_o and frame_err_o keep their values whatever rx_i does.
- R9: A start pulse during a reception restarts all timing from its own edge. The frame that follows is then assembled and timed as in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, 16 per bit period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-clock start pulse from the start detector |
| rx_i | input | 1 | Filtered serial receive line |
| data_o | output | DATA_W | Receive shift register contents |
| done_o | output | 1 | Frame complete, counters frozen |
| frame_err_o | output | 1 | Stop bit sampled as 0 in the current frame |

## Verification
Two events can fall in the same cycle: a start pulse and a mid-bit strobe. The case that matters most is a start pulse on the edge where the stop bit is sampled with the line low. The bench also fires a start pulse on the very edge where done would have risen. In both cases the start pulse must win. frame_err_o and done_o must be 0 right after that edge, and the frame that follows must be assembled and timed from the new start. Full sweeps over all 256 data values with a good stop bit, plus a set of frames with a bad stop bit, judge the data and the flags against values the bench computes from the bit timing.

// File: rtl/rx_seq_pkg.sv
package rx_seq_pkg;

  // bit counter preload so that it reaches all-ones after start + data samples
  function automatic int unsigned bit_preload(int unsigned cnt_w, int unsigned data_w);
    return (2 ** cnt_w) - 1 - (data_w + 1);
  endfunction

  // edges from start edge (counted as 1) until done is raised
  function automatic int unsigned done_edge(int unsigned cnt_w, int unsigned data_w);
    return (data_w + 2) * (2 ** cnt_w) - 1;
  endfunction

endpackage

// File: rtl/rx_seq_counters.sv
module rx_seq_counters #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic cyc_msb_o,
  output logic last_bit_o,
  output logic done_o
);
  import rx_seq_pkg::*;

  localparam logic [CNT_W-1:0] CYC_LOAD = CNT_W'(1);
  localparam logic [CNT_W-1:0] BIT_LOAD = CNT_W'(bit_preload(CNT_W, DATA_W));
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cyc_q, bit_q;
  logic cyc_full, bit_full, frozen;

  assign cyc_full = (cyc_q == CNT_MAX);
  assign bit_full = (bit_q == CNT_MAX);
  assign frozen   = cyc_full & bit_full;

  // cycle counter keeps running through the stop-bit period, then freezes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= CNT_MAX;
      bit_q <= CNT_MAX;
    end else if (load_i) begin
      cyc_q <= CYC_LOAD;
      bit_q <= BIT_LOAD;
    end else if (!frozen) begin
      cyc_q <= cyc_q + CNT_W'(1);
      if (cyc_full && !bit_full) bit_q <= bit_q + CNT_W'(1);
    end
  end

  assign cyc_msb_o  = cyc_q[CNT_W-1];
  assign last_bit_o = bit_full;
  assign done_o     = frozen;

endmodule

// File: rtl/rx_seq_strobe.sv
module rx_seq_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_msb_i,
  output logic strobe_o
);

  logic msb_q;

  // reset high: idle counter sits at all-ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) msb_q <= 1'b1;
    else         msb_q <= cyc_msb_i;
  end

  assign strobe_o = cyc_msb_i & ~msb_q;

endmodule

// File: rtl/rx_seq_shifter.sv
module rx_seq_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              strobe_i,
  input  logic              last_bit_i,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o
);

  logic [DATA_W-1:0] sreg_q;
  logic              ferr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sreg_q <= '0;
    else if (strobe_i && !last_bit_i) sreg_q <= {rx_i, sreg_q[DATA_W-1:1]};
  end

  // start pulse wins over a coincident stop-bit sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ferr_q <= 1'b0;
    else if (start_i)                ferr_q <= 1'b0;
    else if (strobe_i && last_bit_i) ferr_q <= ~rx_i;
  end

  assign data_o      = sreg_q;
  assign frame_err_o = ferr_q;

endmodule

// File: rtl/rx_bit_sequencer.sv
module rx_bit_sequencer #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic              frame_err_o
);

  logic cyc_msb, last_bit, strobe;

  rx_seq_counters #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_i),
    .cyc_msb_o  (cyc_msb),
    .last_bit_o (last_bit),
    .done_o     (done_o)
  );

  rx_seq_strobe u_stb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cyc_msb_i (cyc_msb),
    .strobe_o  (strobe)
  );

  rx_seq_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .strobe_i    (strobe),
    .last_bit_i  (last_bit),
    .rx_i        (rx_i),
    .data_o      (data_o),
    .frame_err_o (frame_err_o)
  );

endmodule

// File: rtl/rx_bit_sequencer_chk.sv
module rx_bit_sequencer_chk #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DATA_W-1:0] data_o,
  input logic              done_o,
  input logic              frame_err_o,
  input logic              strobe
);
  import rx_seq_pkg::*;

  localparam int unsigned LIMIT = done_edge(CNT_W, DATA_W);
  localparam int unsigned EW    = $clog2(LIMIT + 1);

  logic [EW-1:0] edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                edges_q <= EW'(LIMIT);
    else if (start_i)           edges_q <= EW'(1);
    else if (edges_q != LIMIT)  edges_q <= edges_q + EW'(1);
  end

  AST_START_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o); // R2
  AST_DONE_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == (edges_q == EW'(LIMIT))); // R3
  AST_SHIFT_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe |=> $stable(data_o)); // R4
  AST_START_CLEARS_FERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !frame_err_o); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o); // R8
  AST_DATA_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> $stable(data_o)); // R8
  AST_FERR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> $stable(frame_err_o)); // R8

endmodule

bind rx_bit_sequencer rx_bit_sequencer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .data_o      (data_o),
  .done_o      (done_o),
  .frame_err_o (frame_err_o),
  .strobe      (strobe)
);

// File: tb/rx_bit_sequencer_tb_top.sv
module rx_bit_sequencer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int DONE_EDGE  = 159;
  localparam int LAST_DATA  = 137;
  localparam int STOP_EDGE  = 153;
  localparam int RUN_LEN    = 180;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rx = 1'b1;
  logic [DATA_W-1:0] data;
  logic done, ferr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_bit_sequencer #(.CNT_W(4), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rx_i(rx),
    .data_o(data), .done_o(done), .frame_err_o(ferr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // line level for the edge after edge n (slot j = n/16)
  function automatic logic level(input int n, input logic [7:0] d, input logic stop_v);
    int j = n / 16;
    if (j == 0) return 1'b0;
    if (j <= 8) return d[j-1];
    if (j == 9) return stop_v;
    return n[1];
  endfunction

  // call at a negedge; leaves at the negedge after edge n_end
  task automatic frame(input logic [7:0] d, input logic stop_v, input int n_end);
    start = 1'b1;
    rx = 1'b0;
    for (int n = 1; n <= n_end; n++) begin
      @(negedge clk);
      if (n == 1) begin
        start = 1'b0;
        check(done == 1'b0, "R2", done, 0);
        check(ferr == 1'b0, "R7", ferr, 0);
      end
      if (n == LAST_DATA) check(data == d, "R4", data, d);
      if (n == STOP_EDGE - 1) check(ferr == 1'b0, "R7", ferr, 0);
      if (n == STOP_EDGE) check(ferr == ~stop_v, "R6", ferr, ~stop_v);
      if (n == DONE_EDGE - 1) check(done == 1'b0, "R3", done, 0);
      if (n == DONE_EDGE) begin
        check(done == 1'b1, "R3", done, 1);
        check(data == d, "R5", data, d);
      end
      if (n == n_end && n > DONE_EDGE) begin
        check(data == d, "R8", data, d);
        check(ferr == ~stop_v, "R8", ferr, ~stop_v);
        check(done == 1'b1, "R8", done, 1);
      end
      rx = level(n, d, stop_v);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b1, "R1", done, 1);
    check(data == '0, "R1", data, 0);
    check(ferr == 1'b0, "R1", ferr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b1, "R1", done, 1);

    for (int v = 0; v < 256; v++) frame(8'(v), 1'b1, RUN_LEN);
    for (int v = 0; v < 16; v++) frame(8'(v * 17 + 3), 1'b0, RUN_LEN);

    // R9: restart in mid-character
    frame(8'hA5, 1'b1, 70);
    frame(8'h3C, 1'b1, RUN_LEN);
    check(data == 8'h3C, "R9", data, 8'h3C);

    // R7: start on the stop-sample edge with a low stop bit
    frame(8'h81, 1'b0, STOP_EDGE - 1);
    frame(8'h5E, 1'b1, RUN_LEN);
    check(ferr == 1'b0, "R7", ferr, 0);
    check(data == 8'h5E, "R9", data, 8'h5E);

    // R2: start on the edge where done would rise
    frame(8'hF0, 1'b0, DONE_EDGE - 1);
    frame(8'h0F, 1'b1, RUN_LEN);
    check(data == 8'h0F, "R9", data, 8'h0F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule